// File: doc/BRIEF.md
# Boot-Window ROM Bank Mapper

This block translates CPU read addresses in a 4 MB cartridge space into ROM addresses. The CPU has a 24-bit byte address. After reset the block is in boot mode: every address in the space is folded onto the last 8 KB of the ROM, so the boot code shows up throughout the space. Software then writes three byte-wide registers. Two of them each hold part of the bank base address, and the third holds the window size. When both the base and the size have been written, the block checks the window. If the check passes, the window is mirrored across the whole 4 MB space.

A window that does not fit inside the ROM is rejected, and so is a size that is not a power of two. A rejected window leaves the previous translation in force and raises a one-cycle anomaly pulse. A write inside the register region that matches none of the three registers also raises the pulse. The ROM size comes in on a static input. Translation is registered, so a read address presented in one cycle gives its ROM address one clock later.

Top module: `bootwin_mapper`

## Requirements
- R1: After reset the outputs are zero. Until a mapping has been accepted, a read address A below 0x400000 gives rom_valid=1 and rom_addr = rom_size - 0x2000 + A[12:0], one clock after A is presented.
- R2: A write with address 0x400000 loads ROM base bits 21:20 from wr_data[2:1]. It leaves base bits 19:17 unchanged and marks the base as written.
- R3: A write with address 0x404000 loads ROM base bits 19:17 from wr_data[2:0]. It leaves base bits 21:20 unchanged and marks the base as written.
- R4: A write with address 0x402000 sets the window size to wr_data[4:0] × 0x20000 and marks the size as written.
- R5: No window is evaluated until both the base and the size have been written, so boot mode stays in force until then.
- R6: A window is evaluated only on a write that changes the base, the size or a written flag. Rewriting the same values causes no evaluation and no anomaly.
- R7: A window with base + size > rom_size is rejected. The previous translation is kept and anomaly is pulsed one clock after the write. A window with base + size = rom_size is accepted.
- R8: A window whose size is zero or not a power of two is rejected. The previous translation is kept and anomaly is pulsed.
- R9: Once a window is accepted, a read address A below 0x400000 gives rom_valid=1 and rom_addr = base + (A mod size), one clock later.
- R10: A read address at or above 0x400000 gives rom_valid=0 and rom_addr=0, one clock later.
- R11: A write to an address in 0x400000 to 0x40FFFF other than the three register addresses changes nothing and pulses anomaly one clock later. A write outside that region changes nothing and raises no anomaly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | One-cycle byte write strobe |
| wr_addr | input | 24 | Byte address of the write |
| wr_data | input | 8 | Write data byte |
| rd_addr | input | 24 | CPU read address to translate |
| rom_size | input | 23 | ROM size in bytes, static |
| rom_addr | output | 22 | Translated ROM byte address, registered |
| rom_valid | output | 1 | Read address lies in the cartridge space, registered |
| anomaly | output | 1 | One-cycle pulse for a stray register write or a rejected window |

## Verification
The assertions assume that rom_size is held constant, is a multiple of 8 KB, is at least 8 KB and is no more than 4 MB. Under that assumption the boot image and every accepted window lie inside the ROM. They also assume that wr_en is a clean strobe with a known address. The bench drives a single 3 MB ROM size for the whole run. It issues one write at a time, each held for one cycle, and moves the read address only on falling edges. Its writes deliberately reach window sums below, equal to and above that size, so that both the fit and the reject paths are exercised.

// File: rtl/bwm_pkg.sv
package bwm_pkg;

  // Which configuration register a write selects
  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_BASE_HI,
    SEL_BASE_LO,
    SEL_SIZE
  } bwm_sel_e;

  // Default geometry of the cartridge bus
  localparam int unsigned DEF_CPU_AW     = 24;
  localparam int unsigned DEF_SPACE_AW   = 22;
  localparam int unsigned DEF_GRAN_LSB   = 17;
  localparam int unsigned DEF_BOOT_AW    = 13;
  localparam int unsigned DEF_REGION_LSB = 16;

endpackage

// File: rtl/bwm_regs.sv
// Decodes byte writes into the base and size fields and produces the
// next-state view of the fields plus a re-evaluation request.
module bwm_regs
  import bwm_pkg::*;
#(
  parameter int unsigned CPU_AW     = DEF_CPU_AW,
  parameter int unsigned DW         = 8,
  parameter int unsigned HI_W       = 2,
  parameter int unsigned LO_W       = 3,
  parameter int unsigned SZ_W       = 5,
  parameter int unsigned HI_DLSB    = 1,
  parameter int unsigned REGION_LSB = DEF_REGION_LSB,
  parameter logic [CPU_AW-1:0] ADDR_HI = 24'h400000,
  parameter logic [CPU_AW-1:0] ADDR_LO = 24'h404000,
  parameter logic [CPU_AW-1:0] ADDR_SZ = 24'h402000,
  localparam int unsigned BASE_W = HI_W + LO_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [CPU_AW-1:0] wr_addr,
  input  logic [DW-1:0]     wr_data,
  output logic [BASE_W-1:0] base_next,
  output logic [SZ_W-1:0]   size_next,
  output logic              eval_req,
  output logic              stray_wr,
  output logic              size_written
);

  localparam logic [CPU_AW-REGION_LSB-1:0] REGION_ID = ADDR_HI[CPU_AW-1:REGION_LSB];

  bwm_sel_e          sel;
  logic [HI_W-1:0]   hi_q, hi_n;
  logic [LO_W-1:0]   lo_q, lo_n;
  logic [SZ_W-1:0]   sz_q, sz_n;
  logic              bv_q, bv_n;
  logic              sv_q, sv_n;
  logic              in_region;
  logic              unused_wr_data;

  assign unused_wr_data = ^wr_data;

  always_comb begin
    sel = SEL_NONE;
    if (wr_en) begin
      if (wr_addr == ADDR_HI)      sel = SEL_BASE_HI;
      else if (wr_addr == ADDR_LO) sel = SEL_BASE_LO;
      else if (wr_addr == ADDR_SZ) sel = SEL_SIZE;
    end
  end

  assign in_region = wr_en && (wr_addr[CPU_AW-1:REGION_LSB] == REGION_ID);
  assign stray_wr  = in_region && (sel == SEL_NONE);

  always_comb begin
    hi_n = hi_q;
    lo_n = lo_q;
    sz_n = sz_q;
    bv_n = bv_q;
    sv_n = sv_q;
    unique case (sel)
      SEL_BASE_HI: begin
        hi_n = wr_data[HI_DLSB +: HI_W];
        bv_n = 1'b1;
      end
      SEL_BASE_LO: begin
        lo_n = wr_data[LO_W-1:0];
        bv_n = 1'b1;
      end
      SEL_SIZE: begin
        sz_n = wr_data[SZ_W-1:0];
        sv_n = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_q <= '0;
      lo_q <= '0;
      sz_q <= '0;
      bv_q <= 1'b0;
      sv_q <= 1'b0;
    end else begin
      hi_q <= hi_n;
      lo_q <= lo_n;
      sz_q <= sz_n;
      bv_q <= bv_n;
      sv_q <= sv_n;
    end
  end

  // Re-evaluate only when both halves are known and something moved
  assign eval_req = bv_n && sv_n &&
                    ({bv_n, hi_n, lo_n, sv_n, sz_n} != {bv_q, hi_q, lo_q, sv_q, sz_q});

  assign base_next    = {hi_n, lo_n};
  assign size_next    = sz_n;
  assign size_written = sv_q;

endmodule

// File: rtl/bwm_window.sv
// Checks a requested window and holds the accepted translation state.
module bwm_window #(
  parameter int unsigned BASE_W   = 5,
  parameter int unsigned SZ_W     = 5,
  parameter int unsigned GRAN_LSB = 17,
  localparam int unsigned ROM_AW  = BASE_W + GRAN_LSB
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              eval_req,
  input  logic              stray_wr,
  input  logic [BASE_W-1:0] base_next,
  input  logic [SZ_W-1:0]   size_next,
  input  logic [ROM_AW:0]   rom_size,
  output logic              mapped,
  output logic [ROM_AW-1:0] map_base,
  output logic [ROM_AW-1:0] map_mask,
  output logic              anomaly
);

  logic [ROM_AW-1:0] base_b;
  logic [ROM_AW:0]   size_b;
  logic [ROM_AW+1:0] end_b;
  logic              pow2;
  logic              fits;
  logic              accept;

  assign base_b = {base_next, {GRAN_LSB{1'b0}}};
  assign size_b = (ROM_AW+1)'(size_next) << GRAN_LSB;
  assign end_b  = {2'b00, base_b} + {1'b0, size_b};
  assign pow2   = ($countones(size_next) == 1);
  assign fits   = (end_b <= {1'b0, rom_size});
  assign accept = eval_req && pow2 && fits;

  always_ff @(posedge clk) begin
    if (rst) begin
      mapped   <= 1'b0;
      map_base <= '0;
      map_mask <= '0;
      anomaly  <= 1'b0;
    end else begin
      anomaly <= stray_wr || (eval_req && !accept);
      if (accept) begin
        mapped   <= 1'b1;
        map_base <= base_b;
        map_mask <= size_b[ROM_AW-1:0] - 1'b1;
      end
    end
  end

endmodule

// File: rtl/bwm_xlate.sv
// Registered address translation for boot mode and window mode.
module bwm_xlate #(
  parameter int unsigned CPU_AW   = 24,
  parameter int unsigned SPACE_AW = 22,
  parameter int unsigned ROM_AW   = 22,
  parameter int unsigned BOOT_AW  = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CPU_AW-1:0] rd_addr,
  input  logic [ROM_AW:0]   rom_size,
  input  logic              mapped,
  input  logic [ROM_AW-1:0] map_base,
  input  logic [ROM_AW-1:0] map_mask,
  output logic [ROM_AW-1:0] rom_addr,
  output logic              rom_valid
);

  localparam logic [ROM_AW-1:0] BOOT_BYTES = ROM_AW'(1) << BOOT_AW;

  logic              in_space;
  logic [ROM_AW-1:0] boot_base;
  logic [ROM_AW-1:0] xl_addr;
  logic              unused_size_msb;

  assign unused_size_msb = rom_size[ROM_AW];
  assign in_space  = (rd_addr[CPU_AW-1:SPACE_AW] == '0);
  assign boot_base = rom_size[ROM_AW-1:0] - BOOT_BYTES;

  always_comb begin
    if (mapped)
      xl_addr = map_base + (rd_addr[ROM_AW-1:0] & map_mask);
    else
      xl_addr = boot_base + ROM_AW'(rd_addr[BOOT_AW-1:0]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rom_addr  <= '0;
      rom_valid <= 1'b0;
    end else begin
      rom_valid <= in_space;
      rom_addr  <= in_space ? xl_addr : '0;
    end
  end

endmodule

// File: rtl/bootwin_mapper.sv
module bootwin_mapper
  import bwm_pkg::*;
#(
  parameter int unsigned CPU_AW     = DEF_CPU_AW,
  parameter int unsigned DW         = 8,
  parameter int unsigned HI_W       = 2,
  parameter int unsigned LO_W       = 3,
  parameter int unsigned SZ_W       = 5,
  parameter int unsigned HI_DLSB    = 1,
  parameter int unsigned GRAN_LSB   = DEF_GRAN_LSB,
  parameter int unsigned SPACE_AW   = DEF_SPACE_AW,
  parameter int unsigned BOOT_AW    = DEF_BOOT_AW,
  parameter int unsigned REGION_LSB = DEF_REGION_LSB,
  parameter logic [CPU_AW-1:0] ADDR_HI = 24'h400000,
  parameter logic [CPU_AW-1:0] ADDR_LO = 24'h404000,
  parameter logic [CPU_AW-1:0] ADDR_SZ = 24'h402000,
  localparam int unsigned BASE_W = HI_W + LO_W,
  localparam int unsigned ROM_AW = BASE_W + GRAN_LSB
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [CPU_AW-1:0] wr_addr,
  input  logic [DW-1:0]     wr_data,
  input  logic [CPU_AW-1:0] rd_addr,
  input  logic [ROM_AW:0]   rom_size,
  output logic [ROM_AW-1:0] rom_addr,
  output logic              rom_valid,
  output logic              anomaly
);

  logic [BASE_W-1:0] base_next;
  logic [SZ_W-1:0]   size_next;
  logic              eval_req;
  logic              stray_wr;
  logic              size_written;
  logic              mapped;
  logic [ROM_AW-1:0] map_base;
  logic [ROM_AW-1:0] map_mask;

  bwm_regs #(
    .CPU_AW(CPU_AW), .DW(DW), .HI_W(HI_W), .LO_W(LO_W), .SZ_W(SZ_W),
    .HI_DLSB(HI_DLSB), .REGION_LSB(REGION_LSB),
    .ADDR_HI(ADDR_HI), .ADDR_LO(ADDR_LO), .ADDR_SZ(ADDR_SZ)
  ) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .base_next(base_next), .size_next(size_next), .eval_req(eval_req),
    .stray_wr(stray_wr), .size_written(size_written)
  );

  bwm_window #(
    .BASE_W(BASE_W), .SZ_W(SZ_W), .GRAN_LSB(GRAN_LSB)
  ) u_win (
    .clk(clk), .rst(rst), .eval_req(eval_req), .stray_wr(stray_wr),
    .base_next(base_next), .size_next(size_next), .rom_size(rom_size),
    .mapped(mapped), .map_base(map_base), .map_mask(map_mask), .anomaly(anomaly)
  );

  bwm_xlate #(
    .CPU_AW(CPU_AW), .SPACE_AW(SPACE_AW), .ROM_AW(ROM_AW), .BOOT_AW(BOOT_AW)
  ) u_xl (
    .clk(clk), .rst(rst), .rd_addr(rd_addr), .rom_size(rom_size),
    .mapped(mapped), .map_base(map_base), .map_mask(map_mask),
    .rom_addr(rom_addr), .rom_valid(rom_valid)
  );

endmodule

// File: rtl/bootwin_mapper_chk.sv
module bootwin_mapper_chk #(
  parameter int unsigned CPU_AW     = 24,
  parameter int unsigned ROM_AW     = 22,
  parameter int unsigned SPACE_AW   = 22,
  parameter int unsigned BOOT_AW    = 13,
  parameter int unsigned REGION_LSB = 16,
  parameter logic [CPU_AW-1:0] ADDR_HI = 24'h400000,
  parameter logic [CPU_AW-1:0] ADDR_LO = 24'h404000,
  parameter logic [CPU_AW-1:0] ADDR_SZ = 24'h402000
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [CPU_AW-1:0] wr_addr,
  input logic [CPU_AW-1:0] rd_addr,
  input logic [ROM_AW:0]   rom_size,
  input logic [ROM_AW-1:0] rom_addr,
  input logic              rom_valid,
  input logic              anomaly,
  input logic              mapped,
  input logic [ROM_AW-1:0] map_base,
  input logic [ROM_AW-1:0] map_mask,
  input logic              size_written
);

  localparam logic [ROM_AW+1:0] BOOT_BYTES = (ROM_AW+2)'(1) << BOOT_AW;

  logic in_space;
  logic stray;
  assign in_space = (rd_addr[CPU_AW-1:SPACE_AW] == '0);
  assign stray = wr_en && (wr_addr[CPU_AW-1:REGION_LSB] == ADDR_HI[CPU_AW-1:REGION_LSB]) &&
                 (wr_addr != ADDR_HI) && (wr_addr != ADDR_LO) && (wr_addr != ADDR_SZ);

  // R1: reset clears outputs
  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> (!rom_valid && !anomaly && rom_addr == '0));

  // R1: a read in the space is flagged valid
  p_in_space_valid_r1: assert property (@(posedge clk) disable iff (rst)
    in_space |=> rom_valid);

  // R1: boot reads land in the last boot-sized slice with the low bits kept
  p_boot_slice_r1: assert property (@(posedge clk) disable iff (rst)
    (in_space && !mapped) |=>
      (rom_addr[BOOT_AW-1:0] == $past(rd_addr[BOOT_AW-1:0]) &&
       {2'b00, rom_addr} < {1'b0, rom_size} &&
       {2'b00, rom_addr} + BOOT_BYTES >= {1'b0, rom_size}));

  // R5: no window can be active before the size was written
  p_no_map_early_r5: assert property (@(posedge clk) disable iff (rst)
    !size_written |-> !mapped);

  // R5: once active, window mode stays until reset
  p_map_sticky_r5: assert property (@(posedge clk) disable iff (rst)
    mapped |=> mapped);

  // R7: an active window always fits inside the ROM
  p_window_fits_r7: assert property (@(posedge clk) disable iff (rst)
    mapped |-> ({2'b00, map_base} + {2'b00, map_mask} + 1'b1 <= {1'b0, rom_size}));

  // R8: an active window has a power-of-two size
  p_window_pow2_r8: assert property (@(posedge clk) disable iff (rst)
    mapped |-> ($countones({1'b0, map_mask} + 1'b1) == 1));

  // R9: window reads stay inside the window
  p_in_window_r9: assert property (@(posedge clk) disable iff (rst)
    (in_space && mapped) |=>
      (rom_addr >= $past(map_base) &&
       {1'b0, rom_addr} <= {1'b0, $past(map_base)} + {1'b0, $past(map_mask)}));

  // R10: reads outside the space are invalid and zero
  p_out_of_space_r10: assert property (@(posedge clk) disable iff (rst)
    !in_space |=> (!rom_valid && rom_addr == '0));

  // R11: stray register writes raise the anomaly pulse
  p_stray_flag_r11: assert property (@(posedge clk) disable iff (rst)
    stray |=> anomaly);

endmodule

bind bootwin_mapper bootwin_mapper_chk #(
  .CPU_AW(CPU_AW), .ROM_AW(ROM_AW), .SPACE_AW(SPACE_AW), .BOOT_AW(BOOT_AW),
  .REGION_LSB(REGION_LSB), .ADDR_HI(ADDR_HI), .ADDR_LO(ADDR_LO), .ADDR_SZ(ADDR_SZ)
) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .rd_addr(rd_addr),
  .rom_size(rom_size), .rom_addr(rom_addr), .rom_valid(rom_valid),
  .anomaly(anomaly), .mapped(mapped), .map_base(map_base), .map_mask(map_mask),
  .size_written(size_written)
);

// File: tb/bootwin_mapper_test.sv
module bootwin_mapper_test;

  localparam int ROMSZ = 'h300000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [23:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic [23:0] rd_addr = '0;
  logic [22:0] rom_size = 23'(ROMSZ);
  logic [21:0] rom_addr;
  logic        rom_valid;
  logic        anomaly;

  always #5 clk = ~clk;

  bootwin_mapper uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rom_size(rom_size), .rom_addr(rom_addr),
    .rom_valid(rom_valid), .anomaly(anomaly)
  );

  // Behavioural reference state
  int    m_hi, m_lo, m_sz, m_base, m_mask;
  bit    m_bv, m_sv, m_map;
  int    n_hi, n_lo, n_sz, nb, ns, ra;
  bit    n_bv, n_sv;
  int    exp_addr;
  bit    exp_val, exp_an;
  string cur_req = "R1";
  string exp_req = "R1";
  bit    started = 1'b0;
  bit    done = 1'b0;
  int    checks = 0;
  int    errors = 0;
  int    cycles = 0;

  always @(posedge clk) begin
    started = 1'b1;
    exp_req = cur_req;
    if (rst) begin
      m_hi = 0; m_lo = 0; m_sz = 0; m_bv = 0; m_sv = 0;
      m_map = 0; m_base = 0; m_mask = 0;
      exp_addr = 0; exp_val = 0; exp_an = 0;
    end else begin
      ra = int'(rd_addr);
      if (ra < 'h400000) begin
        exp_val = 1;
        if (m_map) exp_addr = m_base + (ra & m_mask);
        else       exp_addr = ROMSZ - 'h2000 + (ra & 'h1FFF);
      end else begin
        exp_val = 0;
        exp_addr = 0;
      end
      exp_an = 0;
      n_hi = m_hi; n_lo = m_lo; n_sz = m_sz; n_bv = m_bv; n_sv = m_sv;
      if (wr_en && wr_addr[23:16] == 8'h40) begin
        if (wr_addr == 24'h400000) begin
          n_hi = (int'(wr_data) >> 1) & 3; n_bv = 1;
        end else if (wr_addr == 24'h404000) begin
          n_lo = int'(wr_data) & 7; n_bv = 1;
        end else if (wr_addr == 24'h402000) begin
          n_sz = int'(wr_data) & 31; n_sv = 1;
        end else begin
          exp_an = 1;
        end
      end
      if (n_bv && n_sv && (n_hi != m_hi || n_lo != m_lo || n_sz != m_sz ||
                           n_bv != m_bv || n_sv != m_sv)) begin
        nb = n_hi * 'h100000 + n_lo * 'h20000;
        ns = n_sz * 'h20000;
        if (ns == 0 || (ns & (ns - 1)) != 0 || nb + ns > ROMSZ) exp_an = 1;
        else begin
          m_map = 1; m_base = nb; m_mask = ns - 1;
        end
      end
      m_hi = n_hi; m_lo = n_lo; m_sz = n_sz; m_bv = n_bv; m_sv = n_sv;
    end
  end

  always @(negedge clk) begin
    if (started && !done) begin
      checks++;
      if (int'(rom_addr) != exp_addr || rom_valid != exp_val || anomaly != exp_an) begin
        errors++;
        $display("FAIL %s: addr=%06h valid=%0d anomaly=%0d expected addr=%06h valid=%0d anomaly=%0d",
                 exp_req, rom_addr, rom_valid, anomaly, exp_addr, exp_val, exp_an);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 200000 && !done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog: cycles=%0d expected completion", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic wr(input logic [23:0] a, input logic [7:0] d, input string r);
    cur_req = r;
    wr_addr = a;
    wr_data = d;
    wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [23:0] a, input string r);
    cur_req = r;
    rd_addr = a;
    @(negedge clk);
  endtask

  task automatic sweep(input string r);
    rd(24'h000000, r); rd(24'h001FFF, r); rd(24'h002000, r);
    rd(24'h07FFFF, r); rd(24'h080000, r); rd(24'h012345, r);
    rd(24'h1ABCDE, r); rd(24'h3FFFFF, r);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    sweep("R1");
    rd(24'h400000, "R10"); rd(24'h800000, "R10"); rd(24'hFFFFFF, "R10");
    // size only: boot stays
    wr(24'h402000, 8'h04, "R5");
    sweep("R5");
    // base low completes the pair: 0x060000 / 512 KB
    wr(24'h404000, 8'h03, "R3");
    sweep("R9");
    // base high: bits 21:20 = 01
    wr(24'h400000, 8'h02, "R2");
    sweep("R2");
    wr(24'h400000, 8'hF9, "R2");
    sweep("R2");
    wr(24'h400000, 8'h02, "R2");
    // base low cleared, high kept: 0x100000
    wr(24'h404000, 8'h00, "R3");
    sweep("R3");
    // 1 MB window
    wr(24'h402000, 8'h08, "R4");
    sweep("R4");
    // non-power-of-two and zero sizes
    wr(24'h402000, 8'h03, "R8");
    sweep("R8");
    wr(24'h402000, 8'h00, "R8");
    wr(24'h400000, 8'h04, "R8");
    sweep("R8");
    // 2 MB at 0x200000 overflows a 3 MB ROM
    wr(24'h402000, 8'h10, "R7");
    sweep("R7");
    // same value again: no evaluation
    wr(24'h402000, 8'h10, "R6");
    rd(24'h000000, "R6");
    // exactly fits
    wr(24'h402000, 8'h08, "R7");
    sweep("R7");
    wr(24'h404000, 8'h01, "R7");
    sweep("R7");
    // stray writes
    wr(24'h400001, 8'h55, "R11");
    wr(24'h402002, 8'h01, "R11");
    wr(24'h40FFFF, 8'hAA, "R11");
    sweep("R11");
    wr(24'h410000, 8'h02, "R11");
    wr(24'h000000, 8'h02, "R11");
    sweep("R11");
    wr(24'h404000, 8'h00, "R9");
    for (int i = 0; i < 300; i++) rd(24'($urandom), "R9");
    // reset again returns to boot mode
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    sweep("R1");
    for (int i = 0; i < 100; i++) rd(24'($urandom), "R10");
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule